// File: doc/BRIEF.md
# Configurable Interrupt Pin Driver

This block turns an internal interrupt condition into the drive for one external interrupt pin. A 2-bit mode code picks one of four pin behaviours. Two are level modes, where the pin follows a pending-interrupt level at either polarity. Two are pulse modes, where each new-interrupt strobe produces a pulse of fixed length at either polarity. The pin is described by a data value and an output enable. An open-drain switch lets the same block drive a wired-OR interrupt line, on which the pin is only ever pulled low.

Every output is registered. The pin therefore reacts on the clock edge that samples the inputs, and it does not glitch between edges. Reset is synchronous and active high. While reset is held, the pin sits at the inactive level of whatever mode is applied at that time.

Top module: `irq_pin_drv`

## Requirements
- R1: Mode code 2'b00 (active-low level): after each clock edge, pin_out is 0 if irq_pending was 1 at that edge and 1 otherwise.
- R2: Mode code 2'b01 (active-high level): after each clock edge, pin_out is 1 if irq_pending was 1 at that edge and 0 otherwise.
- R3: Mode code 2'b10 (low-going pulse): an irq_event sampled at an edge drives pin_out to 0 from that edge for exactly PULSE_LEN (default 4) cycles, after which it returns to 1.
- R4: Mode code 2'b11 (high-going pulse): an irq_event sampled at an edge drives pin_out to 1 from that edge for exactly PULSE_LEN cycles, after which it returns to 0.
- R5: An irq_event that arrives while a pulse is in progress restarts the count, so the pulse ends PULSE_LEN cycles after the latest event.
- R6: When od_en was 0 at the edge, pin_oe is 1. When od_en was 1, pin_oe is 1 only while pin_out is 0, and it is 0 while pin_out is 1.
- R7: At each edge where rst is 1, pin_out takes the inactive level of the applied mode (1 for codes 00 and 10, 0 for codes 01 and 11), pin_oe follows R6, and any pulse is cancelled.
- R8: A change of the mode code takes effect at the next edge. A change with no irq_event at that edge aborts any pulse in progress. A change that coincides with an irq_event starts a new pulse in the new mode.
- R9: irq_pending has no effect in the pulse modes, and irq_event has no effect in the level modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_mode | input | 2 | Pin behaviour code: bit 1 selects pulse mode, bit 0 selects active-high |
| irq_pending | input | 1 | Pending-interrupt level, used in the level modes |
| irq_event | input | 1 | One-cycle strobe marking a new interrupt, used in the pulse modes |
| od_en | input | 1 | 1 selects open-drain drive, 0 selects push-pull drive |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The cases that need care are those where a new-interrupt strobe lands in the same cycle as another action on the pulse counter. One such action is a change of mode code; the other is the count still running from an earlier strobe. The stimulus table therefore switches from low-pulse to high-pulse mode on the very cycle of a strobe, and it also fires a second strobe partway through a high pulse. In both cases the pin is judged cycle by cycle against a pulse that restarts at full length from the latest strobe. A mode change without a strobe is then checked to cut a running pulse short at once.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

    // Bit 1 of the code selects pulse behaviour, bit 0 the active level.
    typedef enum logic [1:0] {
        IRQ_LVL_LO = 2'b00,
        IRQ_LVL_HI = 2'b01,
        IRQ_PLS_LO = 2'b10,
        IRQ_PLS_HI = 2'b11
    } irq_mode_e;

    typedef struct packed {
        irq_mode_e mode;
        logic      pin;
        logic      oe;
    } pin_state_t;

    function automatic logic mode_is_pulse(irq_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_active_high(irq_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_en,
    input  logic start,
    input  logic abort,
    output logic busy_nx
);
    localparam int unsigned CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (rst || !arm_en) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = LOAD;
        end else if (abort) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        busy_nx = (cnt_d != '0);
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/irq_pin_encode.sv
module irq_pin_encode (
    input  logic active,
    input  logic act_high,
    input  logic od_en,
    output logic pin_val,
    output logic oe_val
);
    always_comb begin
        pin_val = active ? act_high : ~act_high;
        oe_val  = od_en ? ~pin_val : 1'b1;
    end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
    import irq_pin_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] irq_mode,
    input  logic       irq_pending,
    input  logic       irq_event,
    input  logic       od_en,
    output logic       pin_out,
    output logic       pin_oe
);
    pin_state_t st_d, st_q;
    irq_mode_e  mode_in;
    logic       mode_chg;
    logic       busy_nx;
    logic       active_nx;
    logic       pin_nx;
    logic       oe_nx;

    assign mode_in  = irq_mode_e'(irq_mode);
    assign mode_chg = (mode_in != st_q.mode);

    irq_pulse_timer #(
        .PULSE_LEN (PULSE_LEN)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .arm_en  (mode_is_pulse(mode_in)),
        .start   (irq_event),
        .abort   (mode_chg),
        .busy_nx (busy_nx)
    );

    always_comb begin
        if (rst) begin
            active_nx = 1'b0;
        end else if (mode_is_pulse(mode_in)) begin
            active_nx = busy_nx;
        end else begin
            active_nx = irq_pending;
        end
    end

    irq_pin_encode enc_i (
        .active   (active_nx),
        .act_high (mode_active_high(mode_in)),
        .od_en    (od_en),
        .pin_val  (pin_nx),
        .oe_val   (oe_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_in;
        st_d.pin  = pin_nx;
        st_d.oe   = oe_nx;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_out = st_q.pin;
    assign pin_oe  = st_q.oe;

endmodule

// File: rtl/irq_pin_drv_chk.sv
module irq_pin_drv_chk #(
    parameter int unsigned PULSE_LEN = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] irq_mode,
    input logic       irq_pending,
    input logic       irq_event,
    input logic       od_en,
    input logic       pin_out,
    input logic       pin_oe
);
    p_level_low_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_mode) == 2'b00) |-> (pin_out == !$past(irq_pending)));

    p_level_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_mode) == 2'b01) |-> (pin_out == $past(irq_pending)));

    p_low_pulse_start_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_mode) == 2'b10 && $past(irq_event)) |-> !pin_out);

    p_high_pulse_start_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_mode) == 2'b11 && $past(irq_event)) |-> pin_out);

    p_open_drain_r6: assert property (@(posedge clk) disable iff (rst)
        $past(od_en) |-> (pin_oe == !pin_out));

    p_push_pull_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(od_en) |-> pin_oe);

    p_reset_idle_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == !$past(irq_mode[0])));

    p_mode_abort_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_mode) != $past(irq_mode, 2) && !$past(irq_event)
         && $past(irq_mode[1])) |-> (pin_out == !$past(irq_mode[0])));

endmodule

bind irq_pin_drv irq_pin_drv_chk #(.PULSE_LEN(PULSE_LEN)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .irq_mode    (irq_mode),
    .irq_pending (irq_pending),
    .irq_event   (irq_event),
    .od_en       (od_en),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe)
);

// File: tb/irq_pin_drv_tb_top.sv
module irq_pin_drv_tb_top;
    localparam int unsigned PULSE_LEN = 4;
    localparam int NVEC = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] irq_mode = 2'b00;
    logic       irq_pending = 1'b0;
    logic       irq_event = 1'b0;
    logic       od_en = 1'b0;
    logic       pin_out;
    logic       pin_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    irq_pin_drv #(.PULSE_LEN(PULSE_LEN)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .irq_mode    (irq_mode),
        .irq_pending (irq_pending),
        .irq_event   (irq_event),
        .od_en       (od_en),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    // [7] rst, [6:5] mode, [4] pending, [3] event, [2] od_en, [1] pin expected, [0] oe expected
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_00_0_0_0_1_1, // R7 reset, active-low level
        8'b1_11_0_0_0_0_1, // R7 reset, high pulse mode idles low
        8'b0_00_0_0_0_1_1, // R1
        8'b0_00_1_0_0_0_1, // R1
        8'b0_00_1_0_0_0_1, // R1
        8'b0_00_0_0_0_1_1, // R1
        8'b0_01_0_0_0_0_1, // R8 switch to active-high level
        8'b0_01_1_0_0_1_1, // R2
        8'b0_01_1_1_0_1_1, // R2
        8'b0_01_0_1_0_0_1, // R9 event ignored in level mode
        8'b0_10_1_0_0_1_1, // R9 pending ignored in pulse mode
        8'b0_10_0_1_0_0_1, // R3 pulse starts
        8'b0_10_0_0_0_0_1, // R3
        8'b0_10_0_0_0_0_1, // R3
        8'b0_10_0_0_0_0_1, // R3
        8'b0_10_0_0_0_1_1, // R3 pulse over
        8'b0_11_0_1_0_1_1, // R4 mode change with event: new pulse
        8'b0_11_0_0_0_1_1, // R4
        8'b0_11_0_0_0_1_1, // R4
        8'b0_11_0_1_0_1_1, // R5 restart
        8'b0_11_0_0_0_1_1, // R5
        8'b0_11_0_0_0_1_1, // R5
        8'b0_11_0_0_0_1_1, // R5
        8'b0_11_0_0_0_0_1, // R5 ends 4 cycles after last event
        8'b0_11_0_1_0_1_1, // R4
        8'b0_10_0_0_0_1_1, // R8 abort by mode change
        8'b0_10_0_0_0_1_1, // R8
        8'b0_00_1_0_1_0_1, // R6 open-drain driving low
        8'b0_00_0_0_1_1_0, // R6 open-drain released
        8'b0_01_1_0_1_1_0, // R6
        8'b0_01_0_0_1_0_1, // R6
        8'b1_10_0_0_1_1_0  // R7 reset with open-drain
    };

    localparam int TAG [NVEC] = '{7,7,1,1,1,1,8,2,2,9,9,3,3,3,3,3,
                                  4,4,4,5,5,5,5,5,4,8,8,6,6,6,6,7};

    task automatic check(input logic exp_pin, input logic exp_oe, input int tag);
        n_checks++;
        if (pin_out !== exp_pin || pin_oe !== exp_oe) begin
            n_fails++;
            $display("FAIL R%0d: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b at %0t",
                     tag, pin_out, pin_oe, exp_pin, exp_oe, $time);
        end
    endtask

    task automatic drive(input logic r, input logic [1:0] m, input logic p,
                         input logic e, input logic o);
        rst = r; irq_mode = m; irq_pending = p; irq_event = e; od_en = o;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3], VEC[i][2]);
            check(VEC[i][1], VEC[i][0], TAG[i]);
        end

        // R3: measure the low pulse width against PULSE_LEN
        drive(1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
        check(1'b1, 1'b1, 7);
        begin
            int width = 0;
            drive(1'b0, 2'b10, 1'b0, 1'b1, 1'b0);
            while (pin_out == 1'b0 && width < 20) begin
                width++;
                drive(1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
            end
            n_checks++;
            if (width != PULSE_LEN) begin
                n_fails++;
                $display("FAIL R3: pulse width %0d expected %0d", width, PULSE_LEN);
            end
        end

        // R7: reset in the middle of a pulse cancels it
        drive(1'b0, 2'b11, 1'b0, 1'b1, 1'b0);
        check(1'b1, 1'b1, 4);
        drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        check(1'b0, 1'b1, 7);
        drive(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        check(1'b0, 1'b1, 7);

        // R6: open-drain in low-pulse mode drives only during the pulse
        drive(1'b0, 2'b10, 1'b0, 1'b0, 1'b1);
        check(1'b1, 1'b0, 6);
        drive(1'b0, 2'b10, 1'b0, 1'b1, 1'b1);
        check(1'b0, 1'b1, 6);
        for (int k = 1; k < int'(PULSE_LEN); k++) begin
            drive(1'b0, 2'b10, 1'b0, 1'b0, 1'b1);
            check(1'b0, 1'b1, 6);
        end
        drive(1'b0, 2'b10, 1'b0, 1'b0, 1'b1);
        check(1'b1, 1'b0, 6);

        // R9: pending held high through a pulse mode never drives the pin
        drive(1'b0, 2'b11, 1'b1, 1'b0, 1'b0);
        check(1'b0, 1'b1, 9);
        drive(1'b0, 2'b11, 1'b1, 1'b0, 1'b0);
        check(1'b0, 1'b1, 9);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule